// File: doc/BRIEF.md
# Split-Capable Raster Timing Generator

This block generates video timing for a character-cell display. One clock is one character time. A horizontal character counter, a raster-in-row counter, a character-row counter and a vertical-adjust counter together produce horizontal sync, vertical sync, a display-enable signal and a refresh memory address. Eleven 8-bit timing registers set its behaviour. Software reaches them by first presenting a register index on a shared byte bus, then a data byte.

The registers can be rewritten while the picture is being drawn, and each write has defined timing. This makes vertical splits possible. The frame can be cut into stacked blocks, each with its own height and its own start address. A new start address is picked up only when the next block begins. Vertical sync fires only when the row counter steps onto the programmed sync row, so a row value that can never be reached holds sync off entirely.

Top module: `raster_timing_gen`

## Requirements
- R1: A cycle with `selStrobe` high latches `busIn[3:0]` as the register index. A cycle with `dataStrobe` high writes `busIn` into the indexed register, and the new value is in effect from the next clock. The index map is: 0 line total, 1 displayed characters, 2 hsync position, 3 sync widths, 4 row total, 5 adjust lines, 6 displayed rows, 7 vsync row, 8 last raster, 9 start address high byte, 10 start address low byte. A write to any other index changes nothing.
- R2: While `rstN` is low, every register and counter is zero, `hSync`, `vSync` and `dispEn` are low, and `memAddr` is 0.
- R3: A line lasts line total + 1 clocks. `hSync` is high from the clock where the character counter equals the hsync position, for N clocks, where N is bits [3:0] of the sync-width register. N = 0 gives no pulse.
- R4: The raster counter steps at each line end and wraps to 0 after the last-raster value, which steps the row counter. After the line that ends with row = row total and raster = last raster, the block gets that many extra adjust lines and then restarts at row 0, raster 0. The block height in lines is (last raster + 1) × (row total + 1) + adjust lines.
- R5: `vSync` rises at character 0 of the line where the row counter steps onto the vsync row, including row 0 at a block start. It stays high for M lines, where M is bits [7:4] of the sync-width register and 0 means 16 lines.
- R6: If the vsync row is never reached (for example 255), `vSync` stays low while blocks keep cycling.
- R7: The start address ({high byte, low byte}) is copied into `memAddr` and the row base only at the first clock of a new block. A write during a block does not change the current block.
- R8: `dispEn` is high only when the character counter is below the displayed-characters value and the row counter is below the displayed-rows value.
- R9: `memAddr` steps by one after each displayed character. At every line end it reloads the row base. After the last raster of a row, the row base grows by the displayed-characters value.
- R10: If the row total is rewritten mid-block to a value above the current row, the running block continues to the new height.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| selStrobe | input | 1 | Latch register index from `busIn[3:0]` |
| dataStrobe | input | 1 | Write `busIn` into the indexed register |
| busIn | input | 8 | Shared index/data byte |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| dispEn | output | 1 | Display enable (low = border) |
| memAddr | output | 16 | Refresh memory address |

## Verification
The bench measures the time between `vSync` rising edges and compares it with the block-height formula, both with and without adjust lines. A design that skipped the adjust phase, or counted one line too many, would come out 10 clocks off. A start address is written in the middle of a block: latching it at once would corrupt the address in the same block's second row, and never latching it would leave the old base in place at the next block. The row total is raised in the middle of a block, and the vsync row is parked at 255; a design that compared with `>=` or fired sync on every raster would produce rising edges that do not belong there. A zero vsync width field must stretch the pulse to 16 lines rather than suppress it.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  // strobes from the counter control to the address datapath
  typedef struct packed {
    logic lineEnd;   // last character clock of a line
    logic charStep;  // displayed character, address advances
    logic rowStep;   // last raster of a row, row base advances
    logic newBlock;  // next clock is first clock of a new block
  } rtgStrobe_t;

  localparam logic [3:0] IDX_HTOT   = 4'd0;
  localparam logic [3:0] IDX_HDISP  = 4'd1;
  localparam logic [3:0] IDX_HPOS   = 4'd2;
  localparam logic [3:0] IDX_SYNCW  = 4'd3;
  localparam logic [3:0] IDX_VTOT   = 4'd4;
  localparam logic [3:0] IDX_VADJ   = 4'd5;
  localparam logic [3:0] IDX_VDISP  = 4'd6;
  localparam logic [3:0] IDX_VPOS   = 4'd7;
  localparam logic [3:0] IDX_MAXRAS = 4'd8;
  localparam logic [3:0] IDX_STHI   = 4'd9;
  localparam logic [3:0] IDX_STLO   = 4'd10;
  localparam int unsigned NUM_REGS  = 11;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selStrobe,
  input  logic          dataStrobe,
  input  logic [DW-1:0] busIn,
  output logic [DW-1:0] hTot,
  output logic [DW-1:0] hDisp,
  output logic [DW-1:0] hPos,
  output logic [3:0]    hsWidth,
  output logic [3:0]    vsWidth,
  output logic [DW-1:0] vTot,
  output logic [DW-1:0] vAdj,
  output logic [DW-1:0] vDisp,
  output logic [DW-1:0] vPos,
  output logic [DW-1:0] maxRas,
  output logic [AW-1:0] startAddr
);
  logic [3:0]    selIdx;
  logic [DW-1:0] regFile [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) selIdx <= '0;
    else if (selStrobe) selIdx <= busIn[3:0];
  end

  // one flop bank per register; unmatched indices write nothing
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) regFile[g] <= '0;
      else if (dataStrobe && selIdx == 4'(g)) regFile[g] <= busIn;
    end
  end

  assign hTot      = regFile[IDX_HTOT];
  assign hDisp     = regFile[IDX_HDISP];
  assign hPos      = regFile[IDX_HPOS];
  assign hsWidth   = regFile[IDX_SYNCW][3:0];
  assign vsWidth   = regFile[IDX_SYNCW][DW-1:4];
  assign vTot      = regFile[IDX_VTOT];
  assign vAdj      = regFile[IDX_VADJ];
  assign vDisp     = regFile[IDX_VDISP];
  assign vPos      = regFile[IDX_VPOS];
  assign maxRas    = regFile[IDX_MAXRAS];
  assign startAddr = {regFile[IDX_STHI], regFile[IDX_STLO]};

  // R1: a data write to the sync-row index lands one clock later
  assert_vpos_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (dataStrobe && selIdx == IDX_VPOS) |=> (vPos == $past(busIn)));
endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] hTot,
  input  logic [DW-1:0] hDisp,
  input  logic [DW-1:0] hPos,
  input  logic [3:0]    hsWidth,
  input  logic [3:0]    vsWidth,
  input  logic [DW-1:0] vTot,
  input  logic [DW-1:0] vAdj,
  input  logic [DW-1:0] vDisp,
  input  logic [DW-1:0] vPos,
  input  logic [DW-1:0] maxRas,
  output rtgStrobe_t    strb,
  output logic          hSync,
  output logic          vSync,
  output logic          dispEn
);
  localparam int unsigned VSW = 5;  // holds widths up to 16

  logic [DW-1:0]  hCnt, rasCnt, rowCnt, adjCnt, nextRow;
  logic           inAdj;
  logic [3:0]     hsCnt;
  logic [VSW-1:0] vsCnt;
  logic lineEnd, lastRas, blockEnd, adjDone, newBlock, rowStep, vsTrig, hsStart;

  always_comb begin
    lineEnd  = (hCnt == hTot);
    lastRas  = (rasCnt == maxRas);
    blockEnd = lineEnd && !inAdj && lastRas && (rowCnt == vTot);
    adjDone  = lineEnd && inAdj && (adjCnt == vAdj - 1'b1);
    newBlock = (blockEnd && vAdj == '0) || adjDone;
    rowStep  = lineEnd && !inAdj && lastRas && (rowCnt != vTot);
    nextRow  = newBlock ? '0 : rowCnt + 1'b1;
    vsTrig   = (newBlock || rowStep) && (nextRow == vPos);
    hsStart  = (hCnt == hPos) && (hsWidth != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt   <= '0;
      rasCnt <= '0;
      rowCnt <= '0;
      adjCnt <= '0;
      inAdj  <= 1'b0;
    end else begin
      hCnt <= lineEnd ? '0 : hCnt + 1'b1;
      if (newBlock) begin
        rowCnt <= '0;
        rasCnt <= '0;
        adjCnt <= '0;
        inAdj  <= 1'b0;
      end else if (blockEnd) begin
        inAdj  <= 1'b1;
        adjCnt <= '0;
      end else if (lineEnd && inAdj) begin
        adjCnt <= adjCnt + 1'b1;
      end else if (rowStep) begin
        rowCnt <= rowCnt + 1'b1;
        rasCnt <= '0;
      end else if (lineEnd) begin
        rasCnt <= rasCnt + 1'b1;
      end
    end
  end

  // sync width down-counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsCnt <= '0;
      vsCnt <= '0;
    end else begin
      if (hsStart) hsCnt <= hsWidth - 4'd1;
      else if (hsCnt != '0) hsCnt <= hsCnt - 4'd1;
      if (lineEnd) begin
        if (vsTrig) vsCnt <= (vsWidth == '0) ? VSW'(16) : {1'b0, vsWidth};
        else if (vsCnt != '0) vsCnt <= vsCnt - 1'b1;
      end
    end
  end

  assign hSync  = hsStart || (hsCnt != '0);
  assign vSync  = (vsCnt != '0);
  assign dispEn = (hCnt < hDisp) && (rowCnt < vDisp);

  assign strb.lineEnd  = lineEnd;
  assign strb.charStep = !lineEnd && (hCnt < hDisp);
  assign strb.rowStep  = rowStep;
  assign strb.newBlock = newBlock;

  // R3: a sync pulse can only begin on the programmed character
  assert_hsync_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hSync) |-> (hCnt == hPos));
  // R5: vertical sync rises on the first character of the sync row
  assert_vsync_row_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vSync) |-> (hCnt == '0 && rowCnt == $past(vPos)));
  // R4: adjust phase begins right after the last raster of the last row
  assert_adjust_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inAdj) |-> (hCnt == '0 && rasCnt == $past(maxRas)));
endmodule

// File: rtl/rtg_addr.sv
module rtg_addr
  import rtg_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  rtgStrobe_t    strb,
  input  logic [DW-1:0] hDisp,
  input  logic [AW-1:0] startAddr,
  output logic [AW-1:0] memAddr
);
  logic [AW-1:0] rowBase, nextBase;

  assign nextBase = rowBase + {{(AW-DW){1'b0}}, hDisp};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowBase <= '0;
      memAddr <= '0;
    end else if (strb.newBlock) begin
      rowBase <= startAddr;
      memAddr <= startAddr;
    end else if (strb.rowStep) begin
      rowBase <= nextBase;
      memAddr <= nextBase;
    end else if (strb.lineEnd) begin
      memAddr <= rowBase;
    end else if (strb.charStep) begin
      memAddr <= memAddr + 1'b1;
    end
  end

  // R7: block start takes the start address that was programmed
  assert_start_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.newBlock |=> (memAddr == $past(startAddr)));
  // R9: displayed characters step the address by one
  assert_char_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.charStep |=> (memAddr == $past(memAddr) + 1'b1));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selStrobe,
  input  logic          dataStrobe,
  input  logic [DW-1:0] busIn,
  output logic          hSync,
  output logic          vSync,
  output logic          dispEn,
  output logic [AW-1:0] memAddr
);
  logic [DW-1:0] hTot, hDisp, hPos, vTot, vAdj, vDisp, vPos, maxRas;
  logic [3:0]    hsWidth, vsWidth;
  logic [AW-1:0] startAddr;
  rtgStrobe_t    strb;

  rtg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .selStrobe(selStrobe), .dataStrobe(dataStrobe),
    .busIn(busIn), .hTot(hTot), .hDisp(hDisp), .hPos(hPos),
    .hsWidth(hsWidth), .vsWidth(vsWidth), .vTot(vTot), .vAdj(vAdj),
    .vDisp(vDisp), .vPos(vPos), .maxRas(maxRas), .startAddr(startAddr)
  );

  rtg_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hTot(hTot), .hDisp(hDisp), .hPos(hPos),
    .hsWidth(hsWidth), .vsWidth(vsWidth), .vTot(vTot), .vAdj(vAdj),
    .vDisp(vDisp), .vPos(vPos), .maxRas(maxRas), .strb(strb),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn)
  );

  rtg_addr #(.DW(DW)) u_addr (
    .clk(clk), .rstN(rstN), .strb(strb), .hDisp(hDisp),
    .startAddr(startAddr), .memAddr(memAddr)
  );
endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selStrobe = 1'b0;
  logic        dataStrobe = 1'b0;
  logic [7:0]  busIn = '0;
  logic        hSync, vSync, dispEn;
  logic [15:0] memAddr;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rstN(rstN), .selStrobe(selStrobe), .dataStrobe(dataStrobe),
    .busIn(busIn), .hSync(hSync), .vSync(vSync), .dispEn(dispEn),
    .memAddr(memAddr)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1: index cycle then data cycle; called and returns on a falling edge
  task automatic wr(input int idx, input int val);
    selStrobe = 1'b1; busIn = 8'(idx);
    @(negedge clk);
    selStrobe = 1'b0; dataStrobe = 1'b1; busIn = 8'(val);
    @(negedge clk);
    dataStrobe = 1'b0;
  endtask

  // scoreboard: expected block periods, popped on each vSync rise
  int   expQ[$];
  int   pending = 0;
  int   cyc = 0;
  int   lastRise = 0;
  int   riseCount = 0;
  bit   haveRise = 0;
  logic vsPrev = 1'b0;
  event riseEv;

  always @(negedge clk) begin
    int e;
    cyc++;
    if (!rstN) begin
      vsPrev = 1'b0;
      haveRise = 0;
    end else begin
      if (vSync && !vsPrev) begin
        if (haveRise && expQ.size() > 0) begin
          e = expQ.pop_front();
          chk("R4 block period", cyc - lastRise, e);
          pending--;
        end
        lastRise = cyc;
        haveRise = 1;
        riseCount++;
        -> riseEv;
      end
      vsPrev = vSync;
    end
  end

  task automatic expectPeriod(input int p);
    expQ.push_back(p);
    pending++;
  endtask

  // walk one block from its vSync rise (offset 0 = row 0, raster 0, char 0)
  task automatic scanBlock(input int len, input int expVs, input int expDisp,
                           input int expHs, input bit detail, input int s);
    int vsHigh = 0, dispHigh = 0, hsHigh = 0;
    for (int i = 0; i < len; i++) begin
      if (vSync) vsHigh++;
      if (dispEn) dispHigh++;
      if (hSync) hsHigh++;
      if (detail) begin
        if (i == 0)  begin chk("R7 start at block begin", memAddr, s);
                           chk("R8 display on at origin", dispEn, 1); end
        if (i == 5)  chk("R9 address steps per char", memAddr, s + 5);
        if (i == 6)  begin chk("R8 horizontal border", dispEn, 0);
                           chk("R3 hsync low before position", hSync, 0); end
        if (i == 7)  chk("R3 hsync at position", hSync, 1);
        if (i == 9)  chk("R3 hsync width ends", hSync, 0);
        if (i == 10) chk("R9 line reload of row base", memAddr, s);
        if (i == 20) chk("R9 row base advance", memAddr, s + 6);
        if (i == 40) begin chk("R9 third row base", memAddr, s + 12);
                           chk("R8 vertical border", dispEn, 0); end
      end
      @(negedge clk);
    end
    chk("R5 vsync width", vsHigh, expVs);
    chk("R8 displayed cycles per block", dispHigh, expDisp);
    chk("R3 hsync cycles per block", hsHigh, expHs);
  endtask

  initial begin
    int snap;
    // R2: reset state
    repeat (3) @(negedge clk);
    chk("R2 reset hSync", hSync, 0);
    chk("R2 reset vSync", vSync, 0);
    chk("R2 reset dispEn", dispEn, 0);
    chk("R2 reset memAddr", memAddr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: config A: 10-char lines, 2 rasters x 3 rows + 1 adjust = 7 lines
    wr(0, 9);  wr(1, 6);  wr(2, 7);  wr(3, 8'h32);
    wr(8, 1);  wr(4, 2);  wr(5, 1);  wr(6, 2);
    wr(9, 8'h01); wr(10, 8'h00); wr(7, 0);
    // R1: unmapped indices must not disturb anything
    wr(11, 8'hFF); wr(15, 8'hFF);
    @(riseEv); @(riseEv);

    @(riseEv);
    expectPeriod(70);
    scanBlock(70, 30, 24, 14, 1, 16'h0100);
    wait (pending == 0);

    // R4: no adjust lines gives 6 lines per block
    wr(5, 0);
    @(riseEv); @(riseEv);
    expectPeriod(60);
    scanBlock(60, 30, 24, 12, 1, 16'h0100);
    wait (pending == 0);

    // R7: start address written mid-block only affects the next block
    @(riseEv);
    repeat (12) @(negedge clk);
    wr(9, 8'h02); wr(10, 8'hA0);
    repeat (4) @(negedge clk);
    chk("R7 current block keeps old base", memAddr, 16'h0106);
    @(riseEv);
    chk("R7 next block takes new start", memAddr, 16'h02A0);

    // R10: raise row total while in row 0: block grows to 10 lines
    @(riseEv);
    wr(4, 4);
    expectPeriod(100);
    wait (pending == 0);

    // R6: unreachable sync row suppresses vSync
    wr(7, 255);
    repeat (2) @(negedge clk);
    snap = riseCount;
    repeat (300) @(negedge clk);
    chk("R6 no vsync with unreachable row", riseCount - snap, 0);
    chk("R6 vsync stays low", vSync, 0);

    // R5: width field 0 means 16 lines; 20-line blocks
    wr(3, 8'h02); wr(4, 9); wr(7, 0);
    @(riseEv);
    expectPeriod(200);
    scanBlock(200, 160, 24, 40, 0, 16'h02A0);
    wait (pending == 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule